// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Core

This block is the execute stage of a processor whose instructions name no operands. A command stream arrives over a ready/valid handshake. Each command is a push of an immediate word, a pop, or one of three two-operand arithmetic operations: add, subtract and multiply. An arithmetic command always reads the two uppermost stack entries. It replaces them with a single result, so the stack shrinks by one entry.

The two uppermost entries live in registers. Deeper entries sit in a small spill memory with one write port and one read port. Every accepted command therefore finishes in a single clock cycle. The top-of-stack word and the entry count are registered outputs. Illegal commands raise one-cycle overflow or underflow pulses and leave the stack as it was.

Top module: `stack_alu_core`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `depth` is 0 and both error flags are 0. `cmd_ready` is 1 from the second cycle after `rst` falls.
- R2: The `cmd_op` encoding is 0 = PUSH, 1 = POP, 2 = ADD, 3 = SUB, 4 = MUL. An accepted PUSH with `depth` below DEPTH places `cmd_imm` on top and raises `depth` by one.
- R3: An accepted POP with `depth` of at least 1 removes the top entry. The entry below it becomes the new top.
- R4: An accepted ADD with at least two entries replaces those two entries with their sum modulo 2^DATA_W. `depth` falls by one.
- R5: SUB yields (second entry − top entry) modulo 2^DATA_W. Pushing 4, 7 and 8, then ADD, PUSH 10, SUB and MUL, leaves one entry equal to 20.
- R6: MUL yields the low DATA_W bits of the product of the two uppermost entries.
- R7: An arithmetic command with fewer than two entries, or a POP with none, leaves the stack unchanged. It drives `unf_err` high for exactly the cycle after acceptance.
- R8: A PUSH when `depth` equals DEPTH is discarded and drives `ovf_err` high for the cycle after acceptance. `depth` never exceeds DEPTH.
- R9: Entries below the two uppermost are unaffected by arithmetic commands. They appear again in order as the stack is popped.
- R10: Nothing changes and no error flag rises while `cmd_valid` is low. An opcode of 5, 6 or 7 is accepted and has no effect.
- R11: The results of a command accepted at a clock edge appear on `tos`, `depth` and the error flags directly after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_imm | input | DATA_W | Immediate word for PUSH |
| cmd_ready | output | 1 | Core accepts a command this cycle |
| tos | output | DATA_W | Top-of-stack word, meaningful when depth > 0 |
| depth | output | $clog2(DEPTH+1) | Number of entries held |
| ovf_err | output | 1 | Overflow pulse |
| unf_err | output | 1 | Underflow pulse |

## Verification
The assertions assume that `cmd_op` and `cmd_valid` are never unknown outside reset. They also assume that no command is presented before `cmd_ready` first rises. The bench meets both assumptions: it holds every input at a defined value from time zero, and it starts issuing commands only after it has observed `cmd_ready` high. The bench drives inputs only on falling edges, so each command is sampled at exactly one rising edge.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4
  } stk_op_e;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_PUSH  = 2'd1,
    ACT_POP   = 2'd2,
    ACT_ARITH = 2'd3
  } stk_act_e;
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             fire,
  input  logic [2:0]       op,
  input  logic [CNT_W-1:0] cur_depth,
  output stk_act_e         act,
  output logic             ovf_hit,
  output logic             unf_hit,
  output logic [CNT_W-1:0] nxt_depth
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);

  always_comb begin
    act       = ACT_NONE;
    ovf_hit   = 1'b0;
    unf_hit   = 1'b0;
    nxt_depth = cur_depth;
    if (fire) begin
      case (op)
        OP_PUSH: begin
          if (cur_depth == FULL) ovf_hit = 1'b1;
          else begin
            act       = ACT_PUSH;
            nxt_depth = cur_depth + ONE;
          end
        end
        OP_POP: begin
          if (cur_depth == '0) unf_hit = 1'b1;
          else begin
            act       = ACT_POP;
            nxt_depth = cur_depth - ONE;
          end
        end
        OP_ADD, OP_SUB, OP_MUL: begin
          if (cur_depth < TWO) unf_hit = 1'b1;
          else begin
            act       = ACT_ARITH;
            nxt_depth = cur_depth - ONE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_MUL:  res = lhs * rhs;
      default: res = rhs;
    endcase
  end
endmodule

// File: rtl/stk_spill_ram.sv
module stk_spill_ram #(
  parameter int DATA_W  = 16,
  parameter int ENTRIES = 6,
  localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/stack_alu_core.sv
module stack_alu_core
  import stk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_imm,
  output logic              cmd_ready,
  output logic [DATA_W-1:0] tos,
  output logic [CNT_W-1:0]  depth,
  output logic              ovf_err,
  output logic              unf_err
);
  localparam int SPILL = DEPTH - 2;
  localparam int AW    = (SPILL > 1) ? $clog2(SPILL) : 1;
  localparam logic [CNT_W-1:0] TWO   = CNT_W'(2);
  localparam logic [CNT_W-1:0] THREE = CNT_W'(3);

  logic [DATA_W-1:0] tos_q, nos_q;
  logic [CNT_W-1:0]  depth_q;
  logic              ovf_q, unf_q, rdy_q;

  stk_act_e          act;
  logic              ovf_hit, unf_hit;
  logic [CNT_W-1:0]  nxt_depth;
  logic [DATA_W-1:0] alu_res, spill_rd;
  logic              spill_we, third_ok;
  logic              fire;

  assign fire = cmd_valid && rdy_q;

  stk_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .fire      (fire),
    .op        (cmd_op),
    .cur_depth (depth_q),
    .act       (act),
    .ovf_hit   (ovf_hit),
    .unf_hit   (unf_hit),
    .nxt_depth (nxt_depth)
  );

  stk_alu #(.DATA_W(DATA_W)) alu_i (
    .op  (cmd_op),
    .lhs (nos_q),
    .rhs (tos_q),
    .res (alu_res)
  );

  assign spill_we = (act == ACT_PUSH) && (depth_q >= TWO);
  assign third_ok = depth_q >= THREE;

  stk_spill_ram #(.DATA_W(DATA_W), .ENTRIES(SPILL)) ram_i (
    .clk     (clk),
    .wr_en   (spill_we),
    .wr_addr (AW'(depth_q - TWO)),
    .wr_data (nos_q),
    .rd_addr (AW'(depth_q - THREE)),
    .rd_data (spill_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tos_q   <= '0;
      nos_q   <= '0;
      depth_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      rdy_q   <= 1'b1;
      ovf_q   <= ovf_hit;
      unf_q   <= unf_hit;
      depth_q <= nxt_depth;
      case (act)
        ACT_PUSH: begin
          tos_q <= cmd_imm;
          nos_q <= tos_q;
        end
        ACT_POP: begin
          tos_q <= nos_q;
          if (third_ok) nos_q <= spill_rd;
        end
        ACT_ARITH: begin
          tos_q <= alu_res;
          if (third_ok) nos_q <= spill_rd;
        end
        default: ;
      endcase
    end
  end

  assign cmd_ready = rdy_q;
  assign tos       = tos_q;
  assign depth     = depth_q;
  assign ovf_err   = ovf_q;
  assign unf_err   = unf_q;
endmodule

// File: rtl/stack_alu_core_chk.sv
module stack_alu_core_chk
  import stk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic             cmd_ready,
  input logic [CNT_W-1:0] depth,
  input logic             ovf_err,
  input logic             unf_err
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);

  logic acc;
  assign acc = cmd_valid && cmd_ready;

  AST_READY_UP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cmd_ready); // R1
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == OP_PUSH && depth != FULL) |=> depth == $past(depth) + ONE); // R2
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == OP_POP && depth != '0) |=> depth == $past(depth) - ONE); // R3
  AST_ARITH_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (acc && (cmd_op == OP_ADD || cmd_op == OP_SUB || cmd_op == OP_MUL) && depth >= TWO)
      |=> depth == $past(depth) - ONE); // R4
  AST_UNF_KEEPS: assert property (@(posedge clk) disable iff (rst)
    unf_err |-> depth == $past(depth)); // R7
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(unf_err && ovf_err)); // R7
  AST_OVF_FULL: assert property (@(posedge clk) disable iff (rst)
    ovf_err |-> (depth == FULL && $past(depth) == FULL)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    depth <= FULL); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> ($stable(depth) && !ovf_err && !unf_err)); // R10
endmodule

bind stack_alu_core stack_alu_core_chk #(.DEPTH(DEPTH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_ready (cmd_ready),
  .depth     (depth),
  .ovf_err   (ovf_err),
  .unf_err   (unf_err)
);

// File: tb/stack_alu_core_tb_top.sv
`timescale 1ns/1ps
module stack_alu_core_tb_top;
  localparam int W  = 8;
  localparam int DP = 4;
  localparam int CW = $clog2(DP + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [W-1:0]  cmd_imm = '0;
  logic          cmd_ready;
  logic [W-1:0]  tos;
  logic [CW-1:0] depth;
  logic          ovf_err, unf_err;

  always #4 clk = ~clk;

  stack_alu_core #(.DATA_W(W), .DEPTH(DP)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_imm(cmd_imm), .cmd_ready(cmd_ready), .tos(tos), .depth(depth),
    .ovf_err(ovf_err), .unf_err(unf_err)
  );

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int mstk [DP];
  int md = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_state(input string tag, input int eo, input int eu);
    chk(int'(depth) == md, tag, "depth", int'(depth), md);
    chk(int'(ovf_err) == eo, tag, "ovf_err", int'(ovf_err), eo);
    chk(int'(unf_err) == eu, tag, "unf_err", int'(unf_err), eu);
    if (md > 0) chk(int'(tos) == mstk[md-1], tag, "tos", int'(tos), mstk[md-1]);
  endtask

  // Drive one command on a falling edge; check on the next falling edge (R11).
  task automatic issue(input int op, input int imm, input string tag);
    int eo = 0;
    int eu = 0;
    int a, b, r;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 3'(op);
    cmd_imm   = W'(imm);
    case (op)
      0: if (md == DP) eo = 1; else begin mstk[md] = imm % 256; md++; end
      1: if (md == 0) eu = 1; else md--;
      2, 3, 4: begin
        if (md < 2) eu = 1;
        else begin
          a = mstk[md-2];
          b = mstk[md-1];
          if (op == 2) r = (a + b) % 256;
          else if (op == 3) r = (a - b + 256) % 256;
          else r = (a * b) % 256;
          mstk[md-2] = r;
          md--;
        end
      end
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1'b0;
    check_state(tag, eo, eu);
  endtask

  task automatic idle_with(input int op, input string tag);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 3'(op);
    cmd_imm   = 8'hA5;
    @(negedge clk);
    check_state(tag, 0, 0);
  endtask

  task automatic drain(input string tag);
    while (md > 0) issue(1, 0, tag);
  endtask

  int vals [5] = '{0, 1, 7, 128, 255};

  initial begin
    repeat (3) @(negedge clk);
    chk(depth == '0, "R1", "depth in reset", int'(depth), 0);
    chk(cmd_ready == 1'b0, "R1", "ready in reset", int'(cmd_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    check_state("R1", 0, 0);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "ready after reset", int'(cmd_ready), 1);

    // R5: the worked sequence ends with a single entry of 20
    issue(0, 4, "R2");
    issue(0, 7, "R2");
    issue(0, 8, "R2");
    issue(2, 0, "R4");
    issue(0, 10, "R2");
    issue(3, 0, "R5");
    issue(4, 0, "R6");
    chk(int'(depth) == 1 && int'(tos) == 20, "R5", "sequence result", int'(tos), 20);
    drain("R3");

    // R4 R5 R6: operand sweep over each arithmetic operation
    for (int op = 2; op <= 4; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++) begin
          issue(0, vals[i], "R2");
          issue(0, vals[j], "R2");
          issue(op, 0, op == 2 ? "R4" : (op == 3 ? "R5" : "R6"));
          drain("R3");
        end

    // R8: fill, overflow, then R9 / R3 ordered drain
    for (int k = 0; k < DP; k++) issue(0, 11 * (k + 1), "R2");
    issue(0, 99, "R8");
    issue(0, 98, "R8");
    issue(1, 0, "R3");
    issue(0, 50, "R2");
    drain("R9");

    // R9: arithmetic with deeper entries present
    issue(0, 3, "R2");
    issue(0, 5, "R2");
    issue(0, 6, "R2");
    issue(0, 9, "R2");
    issue(3, 0, "R9");
    issue(4, 0, "R9");
    issue(2, 0, "R9");
    drain("R9");

    // R7: underflow on empty and single-entry stacks
    issue(1, 0, "R7");
    issue(2, 0, "R7");
    issue(0, 42, "R2");
    issue(3, 0, "R7");
    issue(4, 0, "R7");
    issue(2, 0, "R7");
    chk(int'(tos) == 42, "R7", "tos kept", int'(tos), 42);

    // R10: idle cycles and reserved opcodes
    idle_with(0, "R10");
    idle_with(1, "R10");
    idle_with(2, "R10");
    for (int op = 5; op <= 7; op++) issue(op, 77, "R10");
    drain("R3");
    for (int op = 5; op <= 7; op++) issue(op, 77, "R10");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule